// File: doc/BRIEF.md
# Boundary-Aligned Serial Word Receiver

This block recovers parallel words from a serial data line that travels with its own forwarded bit clock. Both lines arrive as levels already synchronized into the system clock domain and oversampled by it. Each rising edge of the bit clock captures one data bit. The word boundary is carried by the line itself: the data changes while the bit clock stays high, which a well-formed data bit never does. A frame holds 24 data positions and then two boundary periods. The first boundary period samples a 0, and the data toggles to 1 during its high phase. The second period is a plain 1. Any number of idle zero bits may sit between frames.

When a boundary is accepted, the receiver takes the 24 positions that came before the boundary period. Positions 1 to 20 go to the main output. Positions 21 and 22 go to a two-bit side output. Positions 23 and 24 are dropped. A word strobe, held high at rest, drops for a fixed 13 bit periods. The drop starts 6 bit periods after the first bit-clock fall that follows the boundary. Parallel outputs only change while the strobe is high, so a consumer can latch on the strobe's rising edge. An alignment-loss flag reports a line on which no boundary has been seen for too long.

Top module: `bnd_deser`

## Requirements
- R1: A data bit is captured on every rising edge of the bit clock. The first bit captured in a frame is position 1, and it appears on `par_o[0]`.
- R2: A boundary is a change of the data level between two consecutive system-clock samples in which the bit clock is high. The new word is visible on the outputs from the second rising system-clock edge after the toggle reaches the pins, and not at the first.
- R3: Positions 1 to 20 map to `par_o[0]` through `par_o[19]`. Positions 21 and 22 map to `aux_o[0]` and `aux_o[1]`. Positions 23 and 24 have no effect on any output.
- R4: `ckp_o` falls on the sixth bit-clock fall after the first bit-clock fall that follows an accepted boundary. The change shows on the port two system-clock edges after that fall reaches the pins.
- R5: `ckp_o` stays low for exactly 13 bit-clock falls and then returns high.
- R6: When no boundary arrives, `ckp_o` stays high and no pulse is produced.
- R7: During reset and afterwards, `par_o` and `aux_o` read zero and `ckp_o` reads high until the first accepted word. A boundary is accepted only after at least 25 bits have been captured since reset. An earlier boundary changes no output and produces no strobe pulse.
- R8: Idle zero bits between frames, with the bit clock running, do not disturb alignment or the recovered word.
- R9: `loss_o` rises once more than 52 bit-clock falls (two frame lengths) have passed with no boundary. It clears on the edge after the next boundary.
- R10: `par_o` and `aux_o` change only on edges at which `ckp_o` was high. A word accepted while the strobe is low is held and presented as soon as the strobe is high again.
- R11: A boundary accepted while the strobe is low neither lengthens nor shortens that pulse, and it starts no extra pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Forwarded bit clock, sampled level |
| sdat_i | input | 1 | Serial data, sampled level |
| par_o | output | 20 | Recovered positions 1 to 20 |
| aux_o | output | 2 | Recovered positions 21 and 22 |
| ckp_o | output | 1 | Word strobe, low for 13 bit periods per word |
| loss_o | output | 1 | No boundary for more than two frame lengths |

## Verification
Every input passes through one sampling register, so each result shows on the ports at the second rising system-clock edge after the stimulus that causes it. A word appears two edges after the boundary toggle. A strobe edge appears two edges after the qualifying bit-clock fall, which makes the strobe's fall land exactly 13·H+1 cycles after the toggle when a half bit lasts H cycles. The bench drives pins on falling edges and checks on falling edges. Its behavioural model consumes the pin history of the two previous rising edges, so the model and the ports line up cycle for cycle. Directed checks look at one cycle before and one cycle after each due point, and monitors measure the strobe delay and the strobe width in cycles.

// File: rtl/bnd_deser_pkg.sv
package bnd_deser_pkg;

    localparam int FRAME_LEN   = 26;
    localparam int WORD_LEN    = 24;
    localparam int USER_LEN    = 22;
    localparam int MAIN_LEN    = 20;
    localparam int STROBE_WAIT = 6;
    localparam int STROBE_LOW  = 13;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARM   = 2'd1,
        PH_DELAY = 2'd2,
        PH_LOW   = 2'd3
    } ckp_phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic bnd;
    } line_ev_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bd_line_sampler.sv
module bd_line_sampler
    import bnd_deser_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_i,
    input  logic     sdat_i,
    output line_ev_t ev_o,
    output logic     dat_o
);

    logic clk_q, clk_qq, dat_q, dat_qq;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q  <= 1'b0;
            clk_qq <= 1'b0;
            dat_q  <= 1'b0;
            dat_qq <= 1'b0;
        end else begin
            clk_qq <= clk_q;
            clk_q  <= sclk_i;
            dat_qq <= dat_q;
            dat_q  <= sdat_i;
        end
    end

    always_comb begin
        ev_o.rise = clk_q & ~clk_qq;
        ev_o.fall = ~clk_q & clk_qq;
        ev_o.bnd  = clk_q & clk_qq & (dat_q ^ dat_qq);
    end

    assign dat_o = dat_q;

endmodule

// File: rtl/bd_word_assembler.sv
module bd_word_assembler #(
    parameter int DATA_BITS = 24,
    parameter int USER_BITS = 22,
    parameter int MAIN_BITS = 20
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rise_i,
    input  logic                           bnd_i,
    input  logic                           dat_i,
    input  logic                           ckp_i,
    output logic                           accept_o,
    output logic [MAIN_BITS-1:0]           par_o,
    output logic [USER_BITS-MAIN_BITS-1:0] aux_o
);

    localparam int SH_W   = DATA_BITS + 1;
    localparam int FILL_W = $clog2(SH_W + 1);

    logic [SH_W-1:0]      sh_q;
    logic [FILL_W-1:0]    fill_q;
    logic                 full;
    logic [USER_BITS-1:0] user_w;
    logic [USER_BITS-1:0] word_q, hold_q;
    logic                 pend_q;

    assign full     = (fill_q == FILL_W'(SH_W));
    assign accept_o = bnd_i & full;

    // Oldest captured bit (position 1) sits at the top of the shift register.
    for (genvar k = 0; k < USER_BITS; k++) begin : g_pick
        assign user_w[k] = sh_q[SH_W-1-k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            fill_q <= '0;
        end else if (rise_i) begin
            sh_q <= {sh_q[SH_W-2:0], dat_i};
            if (!full) fill_q <= fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            hold_q <= '0;
            pend_q <= 1'b0;
        end else if (accept_o && ckp_i) begin
            word_q <= user_w;
            pend_q <= 1'b0;
        end else if (accept_o) begin
            hold_q <= user_w;
            pend_q <= 1'b1;
        end else if (pend_q && ckp_i) begin
            word_q <= hold_q;
            pend_q <= 1'b0;
        end
    end

    assign par_o = word_q[MAIN_BITS-1:0];
    assign aux_o = word_q[USER_BITS-1:MAIN_BITS];

    assert_stable_low_R10: assert property (@(posedge clk) disable iff (rst)
        !ckp_i |=> ($stable(par_o) && $stable(aux_o)));

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (par_o == '0 && aux_o == '0));

endmodule

// File: rtl/bd_ckp_timer.sv
module bd_ckp_timer
    import bnd_deser_pkg::*;
#(
    parameter int CKP_DELAY = 6,
    parameter int CKP_LOW   = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    input  logic accept_i,
    output logic ckp_o
);

    localparam int CMAX = max2(CKP_DELAY, CKP_LOW);
    localparam int CW   = $clog2(CMAX + 1);

    ckp_phase_e      phase_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            ckp_o   <= 1'b1;
        end else if (accept_i && phase_q != PH_LOW) begin
            phase_q <= PH_ARM;
        end else if (fall_i) begin
            case (phase_q)
                PH_ARM: begin
                    phase_q <= PH_DELAY;
                    cnt_q   <= '0;
                end
                PH_DELAY: begin
                    if (cnt_q == CW'(CKP_DELAY - 1)) begin
                        phase_q <= PH_LOW;
                        cnt_q   <= '0;
                        ckp_o   <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt_q == CW'(CKP_LOW - 1)) begin
                        phase_q <= PH_IDLE;
                        ckp_o   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_ckp_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (ckp_o != $past(ckp_o)) |-> $past(fall_i));

    assert_low_kept_R11: assert property (@(posedge clk) disable iff (rst)
        (accept_i && !ckp_o) |=> !ckp_o);

endmodule

// File: rtl/bd_align_monitor.sv
module bd_align_monitor #(
    parameter int LOSS_LIMIT = 52
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    input  logic bnd_i,
    output logic loss_o
);

    localparam int LW = $clog2(LOSS_LIMIT + 2);

    logic [LW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            loss_o <= 1'b0;
        end else if (bnd_i) begin
            gap_q  <= '0;
            loss_o <= 1'b0;
        end else if (fall_i) begin
            if (gap_q != LW'(LOSS_LIMIT + 1)) gap_q <= gap_q + 1'b1;
            if (gap_q >= LW'(LOSS_LIMIT)) loss_o <= 1'b1;
        end
    end

    assert_loss_clear_R9: assert property (@(posedge clk) disable iff (rst)
        bnd_i |=> !loss_o);

    assert_loss_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(loss_o) |-> $past(fall_i));

endmodule

// File: rtl/bnd_deser.sv
module bnd_deser
    import bnd_deser_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_LEN,
    parameter int DATA_BITS  = WORD_LEN,
    parameter int USER_BITS  = USER_LEN,
    parameter int MAIN_BITS  = MAIN_LEN,
    parameter int CKP_DELAY  = STROBE_WAIT,
    parameter int CKP_LOW    = STROBE_LOW
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           sclk_i,
    input  logic                           sdat_i,
    output logic [MAIN_BITS-1:0]           par_o,
    output logic [USER_BITS-MAIN_BITS-1:0] aux_o,
    output logic                           ckp_o,
    output logic                           loss_o
);

    localparam int LOSS_LIMIT = 2 * FRAME_BITS;

    line_ev_t ev;
    logic     dat;
    logic     accept;

    bd_line_sampler u_samp (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .sdat_i (sdat_i),
        .ev_o   (ev),
        .dat_o  (dat)
    );

    bd_word_assembler #(
        .DATA_BITS (DATA_BITS),
        .USER_BITS (USER_BITS),
        .MAIN_BITS (MAIN_BITS)
    ) u_asm (
        .clk      (clk),
        .rst      (rst),
        .rise_i   (ev.rise),
        .bnd_i    (ev.bnd),
        .dat_i    (dat),
        .ckp_i    (ckp_o),
        .accept_o (accept),
        .par_o    (par_o),
        .aux_o    (aux_o)
    );

    bd_ckp_timer #(
        .CKP_DELAY (CKP_DELAY),
        .CKP_LOW   (CKP_LOW)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .fall_i   (ev.fall),
        .accept_i (accept),
        .ckp_o    (ckp_o)
    );

    bd_align_monitor #(
        .LOSS_LIMIT (LOSS_LIMIT)
    ) u_mon (
        .clk    (clk),
        .rst    (rst),
        .fall_i (ev.fall),
        .bnd_i  (ev.bnd),
        .loss_o (loss_o)
    );

endmodule

// File: tb/tb_bnd_deser.sv
`timescale 1ns/1ps
module tb_bnd_deser;

    localparam int H = 4;          // system cycles per half bit
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        sclk, sdat;
    logic [19:0] par_o;
    logic [1:0]  aux_o;
    logic        ckp_o, loss_o;

    always #2 clk = ~clk;   // 250 MHz

    bnd_deser dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdat_i(sdat),
        .par_o(par_o), .aux_o(aux_o), .ckp_o(ckp_o), .loss_o(loss_o)
    );

    int nvec = 0;
    int nerr = 0;
    int cyc  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          h1c, h1d, h2c, h2d;
    bit          bitq[$];
    int          nfill, mph, mcnt, msince;
    logic [21:0] mp, mhold, w;
    bit          mpend, mckp, mloss, mlive;
    bit          er, ef, eb, acc;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            h1c = 0; h1d = 0; h2c = 0; h2d = 0;
            bitq.delete();
            nfill = 0; mp = '0; mhold = '0; mpend = 0;
            mph = 0; mcnt = 0; mckp = 1; msince = 0; mloss = 0; mlive = 0;
        end else begin
            mlive = 1;
            er = h1c && !h2c;
            ef = !h1c && h2c;
            eb = h1c && h2c && (h1d != h2d);
            acc = eb && (nfill >= 25);
            w = '0;
            if (bitq.size() == 25)
                for (int k = 0; k < 22; k++) w[k] = bitq[k];
            if (acc && mckp) begin mp = w; mpend = 0; end
            else if (acc) begin mhold = w; mpend = 1; end
            else if (mpend && mckp) begin mp = mhold; mpend = 0; end
            if (er) begin
                bitq.push_back(h1d);
                if (bitq.size() > 25) bitq = bitq[1:$];
                nfill++;
            end
            if (acc && mph != 3) mph = 1;
            else if (ef) begin
                case (mph)
                    1: begin mph = 2; mcnt = 0; end
                    2: if (mcnt == 5) begin mph = 3; mcnt = 0; mckp = 0; end else mcnt++;
                    3: if (mcnt == 12) begin mph = 0; mckp = 1; end else mcnt++;
                    default: ;
                endcase
            end
            if (eb) begin msince = 0; mloss = 0; end
            else if (ef) begin msince++; if (msince > 52) mloss = 1; end
            h2c = h1c; h2d = h1d; h1c = sclk; h1d = sdat;
        end
        if (cyc > WATCHDOG) begin
            nerr++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    // ---------------- per-cycle compare and monitors ----------------
    bit ckp_prev = 1;
    int low_run = 0;
    int pulses = 0;
    bit r4_arm = 0;
    int t_bnd = 0;

    always @(negedge clk) begin
        if (mlive) begin
            chk("R3 word vs model", {10'b0, aux_o, par_o}, {10'b0, mp});
            chk("R4 strobe vs model", ckp_o, mckp);
            chk("R9 loss vs model", loss_o, mloss);
            if (!ckp_o) low_run++;
            if (ckp_prev && !ckp_o) begin
                pulses++;
                if (r4_arm) begin
                    chk("R4 strobe delay", cyc - t_bnd, 13 * H + 1);
                    r4_arm = 0;
                end
            end
            if (!ckp_prev && ckp_o) begin
                chk("R5 strobe low width", low_run, 13 * 2 * H);
                low_run = 0;
            end
            ckp_prev = ckp_o;
        end
    end

    // ---------------- stimulus ----------------
    bit          sent[$];
    logic [21:0] last_bw;

    task automatic send_bit(input bit b);
        sdat = b; sclk = 0; sent.push_back(b);
        repeat (H) @(negedge clk);
        sclk = 1;
        repeat (H) @(negedge clk);
    endtask

    task automatic boundary(input bit chk_en, input bit arm);
        logic [21:0] old;
        sdat = 0; sclk = 0; sent.push_back(1'b0);
        for (int k = 0; k < 22; k++) last_bw[k] = sent[sent.size() - 25 + k];
        repeat (H) @(negedge clk);
        sclk = 1;
        @(negedge clk);
        old = {aux_o, par_o};
        sdat = 1;
        if (arm) begin t_bnd = cyc; r4_arm = 1; end
        @(negedge clk);
        if (chk_en) chk("R2 not yet at first edge", {10'b0, aux_o, par_o}, {10'b0, old});
        @(negedge clk);
        if (chk_en) chk("R2 word at second edge", {10'b0, aux_o, par_o}, {10'b0, last_bw});
        repeat (H - 3) @(negedge clk);
        send_bit(1'b1);
    endtask

    task automatic send_frame(input logic [21:0] u, input logic [1:0] x, input int ndata,
                              input bit chk_en, input bit arm);
        logic [23:0] f;
        f = {x, u};
        for (int k = 0; k < ndata; k++) send_bit(f[k]);
        boundary(chk_en, arm);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    int p0;
    logic [19:0] pa;

    initial begin
        rst = 1; sclk = 0; sdat = 0;
        repeat (5) @(negedge clk);
        chk("R7 reset par", par_o, 0);
        chk("R7 reset aux", aux_o, 0);
        chk("R7 reset strobe high", ckp_o, 1);
        chk("R7 reset loss", loss_o, 0);
        rst = 0;

        // early boundary, too few bits captured
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        boundary(1'b0, 1'b0);
        idle(20);
        chk("R7 early boundary ignored", {aux_o, par_o}, 0);
        chk("R7 no early pulse", pulses, 0);

        send_frame(22'h000001, 2'b00, 24, 1, 1);
        chk("R1 first bit to par_o[0]", par_o, 20'h00001);
        send_frame(22'h000000, 2'b11, 24, 1, 1);
        chk("R3 positions 23/24 discarded", {aux_o, par_o}, 0);
        send_frame(22'h300000, 2'b00, 24, 1, 1);
        chk("R3 positions 21/22 to aux", aux_o, 2'b11);
        chk("R3 par clear", par_o, 0);
        send_frame(22'h155555, 2'b10, 24, 1, 1);
        idle(5);
        send_frame(22'h2AAAAA, 2'b01, 24, 1, 1);
        chk("R8 idle bits ignored", {aux_o, par_o}, 22'h2AAAAA);
        idle(20);
        send_frame(22'h3C0F5A, 2'b11, 24, 1, 1);
        chk("R8 long idle ignored", {aux_o, par_o}, 22'h3C0F5A);

        // no boundary: strobe stays high, then loss
        idle(25);
        p0 = pulses;
        idle(40);
        chk("R6 no pulse without boundary", pulses, p0);
        chk("R6 strobe high", ckp_o, 1);
        chk("R9 loss raised", loss_o, 1);
        send_frame(22'h0F0F0F, 2'b00, 24, 1, 1);
        chk("R9 loss cleared", loss_o, 0);

        // boundary while strobe low
        pa = par_o;
        p0 = pulses;
        send_frame(22'h0000FF, 2'b00, 8, 0, 0);
        chk("R10 held while strobe low", par_o, pa);
        chk("R11 strobe still low", ckp_o, 0);
        idle(15);
        chk("R11 single pulse", pulses, p0 + 1);
        chk("R10 deferred word", {aux_o, par_o}, last_bw);

        send_frame(22'h12345A, 2'b01, 24, 1, 1);
        idle(25);
        chk("R5 strobe at rest", ckp_o, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule